// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the device-side read path of a serial NOR flash that is reached over a four-wire SPI link. The host pulls chip select low and clocks in an opcode byte and a 24-bit address. For the fast variant it also clocks in one dummy byte. The block then returns memory bytes on the serial output, most significant bit first, for as long as the host keeps clocking. After each byte the block moves on to the next address by itself. The address space is 18 bits wide and wraps from the top back to zero.

The serial pins are sampled by a faster system clock through synchronizers, and edges of the serial clock are detected in that domain. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) work with the same logic. Memory bytes come from a synchronous read port: the block raises a one-cycle read strobe with an address, and the array returns the byte on the next system clock. A busy input from the rest of the device blocks reads. The serial clock half period must be at least six system clock cycles.

Top module: `sfr_read_engine`

## Requirements
- R1: Opcode 8'h03 is followed by three address bytes, most significant byte and bit first. The first data bit is driven on the falling SCK edge that follows the rising edge sampling the last address bit.
- R2: Opcode 8'h0B is followed by three address bytes and then one ignored dummy byte. SO stays disabled (so_oe low) for the whole header, and data starts on the falling edge after the last dummy bit.
- R3: SI is sampled on rising SCK edges. so_d changes only after falling SCK edges, and each byte goes out most significant bit first.
- R4: While SCK keeps toggling, the read address advances by one after each byte and the next byte follows without a gap.
- R5: The read address is 18 bits wide; after 18'h3FFFF the next byte comes from 18'h00000.
- R6: Address bits 23 to 18 of the received address are ignored.
- R7: so_oe is low whenever cs_n is high. Raising cs_n ends the read, and a partial byte left over from an aborted transfer does not disturb the next transfer.
- R8: Reads work in SPI mode 0 (SCK idles low) and mode 3 (SCK idles high).
- R9: An opcode other than 8'h03 or 8'h0B keeps so_oe low until cs_n rises, and no memory reads are issued.
- R10: If busy is high when the opcode byte completes, the transfer is handled like an unknown opcode.
- R11: mem_rd is a single-cycle strobe with mem_addr valid in the same cycle; mem_rdata is taken on the following clock. A read of N bytes ending with SCK high issues exactly N+1 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the device |
| busy | input | 1 | Device busy; blocks new reads |
| so_d | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; low means high impedance |
| mem_rd | output | 1 | One-cycle read strobe to the array |
| mem_addr | output | 18 | Byte address for the read strobe |
| mem_rdata | input | 8 | Array data, valid one clock after mem_rd |

## Verification
The bench reads across the 18'h3FFFF boundary. A design that saturates or carries into a 19th bit would return the wrong byte after the top address. It sends a 24-bit address with the upper six bits set, which catches a design that lets those bits shift into the live address. It runs a fast read, where a missed or doubled dummy byte shifts the data by one byte, and a mode 3 read, where a design that treats the first falling edge as data would be one bit out of step. It also sends unknown opcodes, reads while busy, and aborts a transfer mid-byte. A design that drives SO in those cases, or keeps a stale bit count after chip select rises, is caught by the output enable checks and by the next transfer's data.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_ADDR = 3'd1,
    ST_DUMY = 3'd2,
    ST_DATA = 3'd3,
    ST_IDLE = 3'd4
  } sfr_state_e;

  localparam logic [7:0] OPC_SLOW = 8'h03;
  localparam logic [7:0] OPC_FAST = 8'h0B;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[g]};
    end
    assign q[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_s,
  output logic rise,
  output logic fall
);
  logic sck_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_p_q <= 1'b0;
    else        sck_p_q <= sck_s;
  end

  assign rise = ~cs_s &  sck_s & ~sck_p_q;
  assign fall = ~cs_s & ~sck_s &  sck_p_q;
endmodule

// File: rtl/sfr_rx_byte.sv
module sfr_rx_byte #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         rise,
  input  logic         si_s,
  output logic         byte_vld,
  output logic [W-1:0] byte_val
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [W-1:0]  byte_q, byte_d;
  logic          vld_q, vld_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d = {sh_q[W-2:0], si_s};
      if (cnt_q == CW'(W-1)) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        byte_d = {sh_q[W-2:0], si_s};
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_val = byte_q;
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 8,
  parameter int unsigned ABYTES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fall,
  input  logic          busy,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_val,
  output logic          so_q_o,
  output logic          oe_q_o,
  output logic          rd_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rdata
);
  localparam int unsigned CW = $clog2(DW);
  localparam int unsigned BW = $clog2(ABYTES + 1);

  sfr_state_e     st_q, st_d;
  logic [BW-1:0]  abyte_q, abyte_d;
  logic           fast_q, fast_d;
  logic [AW-1:0]  addr_q, addr_d, addr_shift;
  logic [DW-1:0]  nxt_q, nxt_d;
  logic [DW-1:0]  obuf_q, obuf_d;
  logic [CW-1:0]  ocnt_q, ocnt_d;
  logic           so_q, so_d;
  logic           oe_q, oe_d;
  logic           rd_q, rd_d;
  logic [AW-1:0]  rdad_q, rdad_d;
  logic           pend_q;

  assign addr_shift = {addr_q[AW-DW-1:0], byte_val};

  always_comb begin
    st_d    = st_q;
    abyte_d = abyte_q;
    fast_d  = fast_q;
    addr_d  = addr_q;
    nxt_d   = pend_q ? rdata : nxt_q;
    obuf_d  = obuf_q;
    ocnt_d  = ocnt_q;
    so_d    = so_q;
    oe_d    = oe_q;
    rd_d    = 1'b0;
    rdad_d  = rdad_q;
    if (clr) begin
      st_d    = ST_OPC;
      abyte_d = '0;
      fast_d  = 1'b0;
      ocnt_d  = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (st_q)
        ST_OPC: if (byte_vld) begin
          if (busy)                       st_d = ST_IDLE;
          else if (byte_val == OPC_SLOW) begin st_d = ST_ADDR; fast_d = 1'b0; end
          else if (byte_val == OPC_FAST) begin st_d = ST_ADDR; fast_d = 1'b1; end
          else                            st_d = ST_IDLE;
        end
        ST_ADDR: if (byte_vld) begin
          addr_d = addr_shift;
          if (abyte_q == BW'(ABYTES - 1)) begin
            abyte_d = '0;
            if (fast_q) begin
              st_d = ST_DUMY;
            end else begin
              st_d   = ST_DATA;
              rd_d   = 1'b1;
              rdad_d = addr_shift;
            end
          end else begin
            abyte_d = abyte_q + BW'(1);
          end
        end
        ST_DUMY: if (byte_vld) begin
          st_d   = ST_DATA;
          rd_d   = 1'b1;
          rdad_d = addr_q;
        end
        ST_DATA: if (fall) begin
          if (ocnt_q == '0) begin
            so_d   = nxt_q[DW-1];
            obuf_d = {nxt_q[DW-2:0], 1'b0};
            oe_d   = 1'b1;
            addr_d = addr_q + AW'(1);
            rd_d   = 1'b1;
            rdad_d = addr_q + AW'(1);
            ocnt_d = CW'(1);
          end else begin
            so_d   = obuf_q[DW-1];
            obuf_d = {obuf_q[DW-2:0], 1'b0};
            ocnt_d = (ocnt_q == CW'(DW-1)) ? '0 : ocnt_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPC;
      abyte_q <= '0;
      fast_q  <= 1'b0;
      addr_q  <= '0;
      nxt_q   <= '0;
      obuf_q  <= '0;
      ocnt_q  <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      rdad_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      abyte_q <= abyte_d;
      fast_q  <= fast_d;
      addr_q  <= addr_d;
      nxt_q   <= nxt_d;
      obuf_q  <= obuf_d;
      ocnt_q  <= ocnt_d;
      so_q    <= so_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      rdad_q  <= rdad_d;
      pend_q  <= rd_q;
    end
  end

  assign so_q_o    = so_q;
  assign oe_q_o    = oe_q;
  assign rd_o      = rd_q;
  assign rd_addr_o = rdad_q;
endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              busy,
  output logic              so_d,
  output logic              so_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned ADDR_BYTES = 3;

  logic [2:0]        pins_s;
  logic              cs_s, sck_s, si_s;
  logic              rise, fall;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_val;
  logic              so_q, oe_q;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
  );
  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[0];

  sfr_edge i_edge (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .rise(rise), .fall(fall)
  );

  sfr_rx_byte #(.W(DATA_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .clr(cs_s), .rise(rise), .si_s(si_s),
    .byte_vld(byte_vld), .byte_val(byte_val)
  );

  sfr_ctrl #(.AW(ADDR_W), .DW(DATA_W), .ABYTES(ADDR_BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(cs_s), .fall(fall), .busy(busy),
    .byte_vld(byte_vld), .byte_val(byte_val), .so_q_o(so_q), .oe_q_o(oe_q),
    .rd_o(mem_rd), .rd_addr_o(mem_addr), .rdata(mem_rdata)
  );

  assign so_d  = so_q;
  assign so_oe = oe_q & ~cs_n;
endmodule

// File: rtl/sfr_read_engine_chk.sv
module sfr_read_engine_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sck,
  input logic              so_d,
  input logic              so_oe,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);
  logic              have_prev_q, fetched_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      fetched_q   <= 1'b0;
      prev_q      <= '0;
    end else if (cs_n) begin
      have_prev_q <= 1'b0;
      fetched_q   <= 1'b0;
    end else if (mem_rd) begin
      have_prev_q <= 1'b1;
      fetched_q   <= 1'b1;
      prev_q      <= mem_addr;
    end
  end

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R4 R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && have_prev_q && !cs_n) |-> (mem_addr == prev_q + ADDR_W'(1)));

  // R1 R2 R9
  oe_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> fetched_q);

  // R3
  so_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$stable(so_d)) |-> !sck);

  // R7
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !mem_rd);
endmodule

bind sfr_read_engine sfr_read_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .so_d(so_d),
  .so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/test_sfr_read_engine.sv
module test_sfr_read_engine;
  localparam int HALF = 8;
  localparam int WD   = 150000;

  logic        clk, rst_n, cs_n, sck, si, busy;
  logic        so_d, so_oe, mem_rd;
  logic [17:0] mem_addr;
  logic [7:0]  mem_rdata;

  int total = 0, fails = 0, rd_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  string      tag_q[$];

  sfr_read_engine i_sfr_read_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .so_d(so_d), .so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] memval(input logic [17:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd3;
    return m ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memval(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops received bytes and compares with expected items
  initial begin
    forever begin
      wait (rx_q.size() > 0);
      begin
        logic [7:0] g, e;
        string t;
        g = rx_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, g, e);
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, inout bit oe_any);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so_d;
      if (so_oe !== 1'b0) oe_any = 1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic finish_txn(input bit m3, input string tag);
    sck = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(so_oe === 1'b0, {tag, " R7 so_oe off after cs_n high"}, so_oe, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_txn(input logic [7:0] op, input logic [23:0] a, input int n,
                        input bit m3, input string tag);
    logic [7:0] rx;
    bit hdr_oe = 0;
    bit dat_oe = 0;
    sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(op, rx, hdr_oe);
    xfer(a[23:16], rx, hdr_oe);
    xfer(a[15:8], rx, hdr_oe);
    xfer(a[7:0], rx, hdr_oe);
    if (op == 8'h0B) xfer(8'hFF, rx, hdr_oe);
    chk(!hdr_oe, {tag, " R1 R2 so_oe low during header"}, hdr_oe, 0);
    for (int i = 0; i < n; i++) begin
      logic [17:0] ea;
      ea = a[17:0] + 18'(i);
      exp_q.push_back(memval(ea));
      tag_q.push_back($sformatf("%s byte %0d", tag, i));
      xfer(8'h00, rx, dat_oe);
      rx_q.push_back(rx);
    end
    chk(dat_oe, {tag, " R1 so_oe driven in data"}, dat_oe, 1);
    finish_txn(m3, tag);
  endtask

  task automatic dead_txn(input logic [7:0] op, input bit bz, input string tag);
    logic [7:0] rx;
    bit any = 0;
    int c0;
    busy = bz;
    sck  = 1'b0;
    c0   = rd_cnt;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(op, rx, any);
    busy = 1'b0;
    for (int i = 0; i < 5; i++) xfer(8'h00, rx, any);
    chk(!any, {tag, " so_oe stays low"}, any, 0);
    chk(rd_cnt == c0, {tag, " no memory reads"}, rd_cnt - c0, 0);
    finish_txn(1'b0, tag);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; busy = 1'b0;
    repeat (5) @(negedge clk);
    chk(so_oe === 1'b0, "reset R7 so_oe low", so_oe, 0);
    chk(mem_rd === 1'b0, "reset R11 mem_rd low", mem_rd, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd_txn(8'h03, 24'h000100, 4, 1'b0, "R1 R3 R4 slow read mode0");
    rd_txn(8'h0B, 24'h012345, 3, 1'b0, "R2 fast read mode0");
    rd_txn(8'h03, 24'h03FFFE, 4, 1'b0, "R5 wrap read");
    rd_txn(8'h0B, 24'h03FFFF, 2, 1'b1, "R5 R8 fast wrap mode3");
    rd_txn(8'h03, 24'hFC0010, 2, 1'b0, "R6 upper bits ignored");

    begin
      int c0;
      c0 = rd_cnt;
      rd_txn(8'h03, 24'h02A0F0, 3, 1'b1, "R8 slow read mode3");
      chk(rd_cnt - c0 == 4, "R11 strobes per mode3 read", rd_cnt - c0, 4);
    end

    dead_txn(8'h9F, 1'b0, "R9 unknown opcode");
    dead_txn(8'h03, 1'b1, "R10 busy at opcode");

    // R7 abort mid-byte, then a clean read
    sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b0; si = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    finish_txn(1'b0, "R7 abort");
    rd_txn(8'h03, 24'h000777, 2, 1'b0, "R7 read after abort");

    wait (rx_q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule